// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Paired Result Registers

This block is the integer multiply and divide engine that sits beside a processor's main datapath. A one-cycle start pulse hands it an operation code, a signedness bit and two 32-bit operands. It then iterates for a fixed number of cycles and writes a 64-bit answer into two architectural result registers, called HI and LO here. The contents of both registers are always visible on two read ports, so a move-from-HI or move-from-LO instruction is a plain read. A three-operand multiply takes its answer from the LO port.

There are three operations. A multiply places the upper half of the 64-bit product in HI and the lower half in LO. A multiply-accumulate adds the 64-bit product to the current HI:LO pair. A divide leaves the remainder in HI and the quotient in LO. Signed operands are handled as magnitudes, and the signs are applied in a final fix-up step. The unit raises no trap. Division by zero completes normally with a defined result.

The controller has three states. IDLE waits for a start. LOOP runs one multiplier bit or one quotient bit per cycle. FIX applies signs, accumulates or handles the zero divisor, then writes HI and LO. The transitions are as follows:
- IDLE to LOOP when a valid start is accepted.
- LOOP to LOOP while the iteration counter is below its last value.
- LOOP to FIX after the last iteration.
- FIX to IDLE unconditionally.

Top module: `mdu_hilo`

## Requirements
- R1: With op code 0 (multiply) and the signed bit set, HI:LO becomes the 64-bit two's-complement product of the operands, HI holding bits 63..32.
- R2: With the signed bit clear, multiply, multiply-accumulate and divide treat both operands as unsigned numbers.
- R3: With op code 1 (multiply-accumulate), HI:LO becomes the previous HI:LO plus the 64-bit product, wrapping modulo 2^64.
- R4: With op code 2 (divide) and a nonzero divisor, LO receives the quotient truncated toward zero and HI the remainder. In signed mode the quotient is negative when the operand signs differ and the remainder has the dividend's sign. The most negative dividend divided by -1 yields LO = 0x80000000 and HI = 0.
- R5: A divide by zero completes normally with LO = 0xFFFFFFFF and HI = the dividend as given.
- R6: busy rises on the cycle after an accepted start and stays high for 33 cycles. On the 34th cycle after the accepting edge, busy is low and done is high, and HI/LO show the new result.
- R7: A start asserted while busy is high is ignored: the running operation finishes with its original operands and op code.
- R8: HI and LO read zero after reset and change only in the cycle where done is high. A start with op code 3 is ignored and leaves busy low and HI/LO unchanged.
- R9: done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears HI, LO and the controller |
| start | input | 1 | Start request, accepted only in IDLE |
| op | input | 2 | 0 multiply, 1 multiply-accumulate, 2 divide, 3 reserved |
| sgn | input | 1 | 1 signed operands, 0 unsigned |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in LOOP or FIX |
| done | output | 1 | One-cycle pulse when HI/LO have been written |
| hi_rd | output | 32 | Current HI register (move-from-HI) |
| lo_rd | output | 32 | Current LO register (move-from-LO) |

## Verification
Several properties are checked on every cycle:
- done lasts a single cycle.
- HI and LO never move outside a done cycle.
- An accepted start always raises busy.
- A start arriving during busy leaves the latched op code and operands unchanged.
- The running partial remainder stays below the divisor.
- The product accumulator holds whenever the remaining multiplier is zero.

The arithmetic results can only be shown by the bench's scenarios. These are:
- sign combinations;
- the most negative operands;
- the zero divisor;
- accumulation chains;
- the exact 34-cycle latency;
- the ignored reserved code.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_MAC = 2'd1,
        OP_DIV = 2'd2,
        OP_RSV = 2'd3
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FIX  = 2'd2
    } mdu_st_e;
endpackage

// File: rtl/mdu_mul_iter.sv
module mdu_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mc_in,
    input  logic [W-1:0]   mp_in,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc;
    logic [PW-1:0] mcand;
    logic [W-1:0]  mplier;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= {{W{1'b0}}, mc_in};
            mplier <= mp_in;
        end else if (step) begin
            if (mplier[0]) begin
                acc <= acc + mcand;
            end
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
        end
    end

    assign prod = acc;

    // R1: once no multiplier bits remain, further steps add nothing
    p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mplier == '0) |=> $stable(acc));
endmodule

// File: rtl/mdu_div_iter.sv
module mdu_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dvs_in,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] dvs;
    logic [W-1:0] q_sh;
    logic [W-1:0] r_acc;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         fits;

    always_comb begin
        trial = {r_acc, q_sh[W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvs   <= '0;
            q_sh  <= '0;
            r_acc <= '0;
        end else if (load) begin
            dvs   <= dvs_in;
            q_sh  <= dvd_in;
            r_acc <= '0;
        end else if (step) begin
            r_acc <= fits ? diff[W-1:0] : trial[W-1:0];
            q_sh  <= {q_sh[W-2:0], fits};
        end
    end

    assign quo = q_sh;
    assign rem = r_acc;

    // R4: restoring step keeps the partial remainder below the divisor
    p_rem_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dvs != '0) |=> (r_acc < dvs));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic         sgn,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi_rd,
    output logic [W-1:0] lo_rd
);
    import mdu_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int PW = 2 * W;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mdu_st_e       st, st_nx;
    logic [CW-1:0] cnt;
    mdu_op_e       op_q;
    logic          neg_prod, neg_quo, neg_rem, dvs_zero;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  hi_q, lo_q;
    logic          done_q;

    logic          accept;
    logic          stepping;
    logic [W-1:0]  mag_a, mag_b;
    logic [PW-1:0] prod_u, prod_s, mac_sum;
    logic [W-1:0]  quo_u, rem_u, quo_s, rem_s;

    // operand magnitudes for the iterators
    always_comb begin
        accept   = (st == ST_IDLE) && start && (mdu_op_e'(op) != OP_RSV);
        stepping = (st == ST_LOOP);
        mag_a    = (sgn && opa[W-1]) ? (~opa + 1'b1) : opa;
        mag_b    = (sgn && opb[W-1]) ? (~opb + 1'b1) : opb;
    end

    mdu_mul_iter #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (stepping),
        .mc_in (mag_a),
        .mp_in (mag_b),
        .prod  (prod_u)
    );

    mdu_div_iter #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (stepping),
        .dvd_in (mag_a),
        .dvs_in (mag_b),
        .quo    (quo_u),
        .rem    (rem_u)
    );

    // sign fix-up and accumulation
    always_comb begin
        prod_s  = neg_prod ? (~prod_u + 1'b1) : prod_u;
        mac_sum = {hi_q, lo_q} + prod_s;
        quo_s   = neg_quo ? (~quo_u + 1'b1) : quo_u;
        rem_s   = neg_rem ? (~rem_u + 1'b1) : rem_u;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) st_nx = ST_LOOP;
            ST_LOOP: if (cnt == LAST) st_nx = ST_FIX;
            ST_FIX:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                cnt <= '0;
            end else if (stepping) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs: latched command, result registers, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_MUL;
            neg_prod <= 1'b0;
            neg_quo  <= 1'b0;
            neg_rem  <= 1'b0;
            dvs_zero <= 1'b0;
            dvd_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q     <= mdu_op_e'(op);
                neg_prod <= sgn && (opa[W-1] ^ opb[W-1]);
                neg_quo  <= sgn && (opa[W-1] ^ opb[W-1]);
                neg_rem  <= sgn && opa[W-1];
                dvs_zero <= (opb == '0);
                dvd_q    <= opa;
            end
            if (st == ST_FIX) begin
                done_q <= 1'b1;
                unique case (op_q)
                    OP_MUL: {hi_q, lo_q} <= prod_s;
                    OP_MAC: {hi_q, lo_q} <= mac_sum;
                    OP_DIV: begin
                        if (dvs_zero) begin
                            hi_q <= dvd_q;
                            lo_q <= '1;
                        end else begin
                            hi_q <= rem_s;
                            lo_q <= quo_s;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy  = (st != ST_IDLE);
    assign done  = done_q;
    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hilo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi_rd) && $stable(lo_rd)));

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op != 2'd3) |=> busy);

    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_restart_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(dvd_q)));
endmodule

// File: tb/sim_mdu_hilo.sv
module sim_mdu_hilo;
    localparam int TCLK = 10;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        sgn = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done;
    logic [31:0] hi_rd, lo_rd;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] exp_hi = '0;
    logic [31:0] exp_lo = '0;

    mdu_hilo u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sgn(sgn),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .hi_rd(hi_rd), .lo_rd(lo_rd)
    );

    always #(TCLK/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic s, input logic [31:0] a, input logic [31:0] b);
        longint unsigned pa, pb;
        if (s) begin
            pa = {{32{a[31]}}, a};
            pb = {{32{b[31]}}, b};
        end else begin
            pa = {32'd0, a};
            pb = {32'd0, b};
        end
        return pa * pb;
    endfunction

    // returns {remainder, quotient}
    function automatic logic [63:0] ref_div(input logic s, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        if (b == 32'd0) return {a, 32'hFFFF_FFFF};
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end else begin
            sa = longint'({32'd0, a});
            sb = longint'({32'd0, b});
        end
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic model(input logic [1:0] o, input logic s, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] v;
        case (o)
            2'd0: v = ref_prod(s, a, b);
            2'd1: v = {exp_hi, exp_lo} + ref_prod(s, a, b);
            default: v = ref_div(s, a, b);
        endcase
        {exp_hi, exp_lo} = v;
    endtask

    // run one op; inject drives a competing start while busy (R7)
    task automatic run_op(input string req, input logic [1:0] o, input logic s,
                          input logic [31:0] a, input logic [31:0] b, input bit inject);
        @(negedge clk);
        start = 1'b1; op = o; sgn = s; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = $urandom; opb = $urandom; sgn = ~s;
        model(o, s, a, b);
        chk("R6 busy after accept", {63'd0, busy}, 64'd1);
        for (int k = 2; k <= 34; k++) begin
            @(negedge clk);
            if (inject && k == 5) begin
                start = 1'b1; op = 2'd2; opa = $urandom; opb = 32'd0;
            end else begin
                start = 1'b0;
            end
            if (k == 33) chk("R6 still busy", {63'd0, busy}, 64'd1);
        end
        chk("R6 done at cycle 34", {62'd0, busy, done}, 64'd1);
        chk(req, {hi_rd, lo_rd}, {exp_hi, exp_lo});
        @(negedge clk);
        chk("R9 done single pulse", {63'd0, done}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R8 reset state", {hi_rd, lo_rd}, 64'd0);
        chk("R8 reset idle", {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R1 signed multiply", 2'd0, 1'b1, 32'hFFFF_FFFD, 32'd7, 1'b0);
        run_op("R1 min*min", 2'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R2 unsigned multiply", 2'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R3 accumulate", 2'd1, 1'b1, 32'hFFFF_FFFF, 32'd5, 1'b0);
        run_op("R3 accumulate wrap", 2'd1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R4 signed divide neg dividend", 2'd2, 1'b1, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R4 signed divide neg divisor", 2'd2, 1'b1, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op("R4 min over -1", 2'd2, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R2 unsigned divide", 2'd2, 1'b0, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R5 divide by zero", 2'd2, 1'b1, 32'h8765_4321, 32'd0, 1'b0);
        run_op("R7 start ignored while busy", 2'd0, 1'b1, 32'd12345, 32'hFFFF_0001, 1'b1);

        // R8: reserved code ignored, registers hold
        @(negedge clk);
        start = 1'b1; op = 2'd3; opa = 32'd9; opb = 32'd9;
        @(negedge clk);
        start = 1'b0;
        chk("R8 reserved op ignored", {63'd0, busy}, 64'd0);
        repeat (5) @(negedge clk);
        chk("R8 HI/LO hold", {hi_rd, lo_rd}, {exp_hi, exp_lo});

        for (int n = 0; n < 60; n++) begin
            logic [1:0] o;
            logic [31:0] a, b;
            o = 2'($urandom_range(0, 2));
            a = $urandom;
            b = (n % 9 == 0) ? 32'd0 : ((n % 2 == 0) ? $urandom : 32'($urandom_range(1, 300)));
            run_op("R1 R2 R3 R4 random", o, 1'($urandom), a, b, (n % 7 == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule